// File: doc/BRIEF.md
# Converter Power-Down and Init Sequencer

This block sequences the capture (analog-to-digital) and playback (digital-to-analog) paths of an audio codec through power-down, initialisation and normal operation. Each path has its own active-low power-down control. The block synchronises both controls and the frame (LRCK) sample clock into the internal clock domain. From them it drives a reset to each path's digital filters and reports the state of each path.

When the capture control is released, the capture path does not deliver data at once. It passes through an initialisation window that lasts a fixed number of LRCK rising edges, 2081 by default, and its serial data word is held at zero for that whole window. The playback path has no such window: it goes from power-down straight to normal operation. It neither delays the capture count nor is delayed by it. Dropping the capture control during the window cancels it, and the next wake-up starts the count from zero.

Top module: `cvt_pwr_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, both states read 2'b00, both filter resets are high and `cap_dout` is zero.
- R2: The capture state is 2'b00 whenever the synchronised capture control is low. In that state `cap_filt_rst` is high and `cap_dout` is zero.
- R3: After the capture control rises, the capture state is 2'b01, `cap_filt_rst` is low and `cap_dout` is zero. The state becomes 2'b10 once INIT_LRCK rising edges of `lrck` have been seen in state 2'b01, and never earlier.
- R4: In capture state 2'b10, `cap_dout` equals `cap_din` in the same cycle.
- R5: Pulling the capture control low during 2'b01 returns the path to 2'b00 and clears the edge count, so the next wake-up needs the full INIT_LRCK edges again.
- R6: The playback state goes directly between 2'b00 and 2'b10 and never reads 2'b01. `play_filt_rst` is high exactly in 2'b00.
- R7: Changes of `play_pd_n` neither change the capture state nor alter the capture edge count.
- R8: The state codes are 2'b00 power-down, 2'b01 init and 2'b10 normal. Code 2'b11 never appears on either state output.
- R9: A change on a power-down input is seen in the state outputs after the third rising clock edge following the change, because of the two-flop synchroniser. It is not seen after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pd_n | input | 1 | Capture path control, low = power-down (asynchronous) |
| play_pd_n | input | 1 | Playback path control, low = power-down (asynchronous) |
| lrck | input | 1 | Frame sample clock (asynchronous to clk) |
| cap_din | input | DATA_W | Capture sample from the decimation filter |
| cap_dout | output | DATA_W | Capture sample toward the serial port, zero unless in normal state |
| cap_filt_rst | output | 1 | Reset to the capture filters |
| play_filt_rst | output | 1 | Reset to the playback filters |
| cap_state | output | 2 | Capture path state code |
| play_state | output | 2 | Playback path state code |

## Verification
The bench builds the block with INIT_LRCK set to 6 and keeps DATA_W at 20 and SYNC_STAGES at 2. A short window puts both edges of the init count within a few dozen LRCK pulses: one edge short of the limit, and exactly on it. The same short window lets the bench repeat wake-ups cut short at random points, together with random playback toggles. With two synchroniser stages the three-edge latency to the state outputs is fixed, so the bench can sample each input change at the exact edge where it takes effect.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [1:0] {
        PS_OFF  = 2'b00,
        PS_INIT = 2'b01,
        PS_RUN  = 2'b10
    } path_state_e;

    function automatic logic holds_reset(path_state_e s);
        return s == PS_OFF;
    endfunction

    function automatic logic data_open(path_state_e s);
        return s == PS_RUN;
    endfunction

endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cps_cap_fsm.sv
module cps_cap_fsm
    import cps_pkg::*;
#(
    parameter int INIT_LRCK = 2081
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        on,
    input  logic        tick,
    output path_state_e state
);
    localparam int CNT_W = $clog2(INIT_LRCK + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_LRCK - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_OFF;
            cnt   <= '0;
        end else begin
            case (state)
                PS_OFF: begin
                    cnt <= '0;
                    if (on) state <= PS_INIT;
                end
                PS_INIT: begin
                    if (!on) begin
                        state <= PS_OFF;
                        cnt   <= '0;
                    end else if (tick) begin
                        if (cnt == LAST) begin
                            state <= PS_RUN;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PS_RUN: begin
                    if (!on) state <= PS_OFF;
                end
                default: state <= PS_OFF;
            endcase
        end
    end
endmodule

// File: rtl/cps_play_fsm.sv
module cps_play_fsm
    import cps_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        on,
    output path_state_e state
);
    always_ff @(posedge clk) begin
        if (rst)     state <= PS_OFF;
        else if (on) state <= PS_RUN;
        else         state <= PS_OFF;
    end
endmodule

// File: rtl/cvt_pwr_seq.sv
module cvt_pwr_seq
    import cps_pkg::*;
#(
    parameter int DATA_W      = 20,
    parameter int INIT_LRCK   = 2081,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_pd_n,
    input  logic              play_pd_n,
    input  logic              lrck,
    input  logic [DATA_W-1:0] cap_din,
    output logic [DATA_W-1:0] cap_dout,
    output logic              cap_filt_rst,
    output logic              play_filt_rst,
    output logic [1:0]        cap_state,
    output logic [1:0]        play_state
);
    localparam int N_SYNC = 3;

    logic [N_SYNC-1:0] raw_in, synced;
    logic              lrck_prev, lrck_rise;
    path_state_e       cap_st, play_st;

    assign raw_in = {lrck, play_pd_n, cap_pd_n};

    cps_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (synced)
    );

    always_ff @(posedge clk) begin
        if (rst) lrck_prev <= 1'b0;
        else     lrck_prev <= synced[2];
    end
    assign lrck_rise = synced[2] & ~lrck_prev;

    cps_cap_fsm #(.INIT_LRCK(INIT_LRCK)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .on    (synced[0]),
        .tick  (lrck_rise),
        .state (cap_st)
    );

    cps_play_fsm u_play (
        .clk   (clk),
        .rst   (rst),
        .on    (synced[1]),
        .state (play_st)
    );

    assign cap_dout      = data_open(cap_st) ? cap_din : '0;
    assign cap_filt_rst  = holds_reset(cap_st);
    assign play_filt_rst = holds_reset(play_st);
    assign cap_state     = cap_st;
    assign play_state    = play_st;
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
    parameter int DATA_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cap_state,
    input logic [1:0]        play_state,
    input logic              cap_filt_rst,
    input logic              play_filt_rst,
    input logic [DATA_W-1:0] cap_din,
    input logic [DATA_W-1:0] cap_dout
);
    p_off_reset_r2: assert property (@(posedge clk) disable iff (rst)
        cap_state == 2'b00 |-> cap_filt_rst && cap_dout == '0);

    p_init_mute_r3: assert property (@(posedge clk) disable iff (rst)
        cap_state == 2'b01 |-> cap_dout == '0 && !cap_filt_rst);

    p_no_skip_r3: assert property (@(posedge clk) disable iff (rst)
        cap_state == 2'b00 |=> cap_state != 2'b10);

    p_run_pass_r4: assert property (@(posedge clk) disable iff (rst)
        cap_state == 2'b10 |-> cap_dout == cap_din);

    p_play_direct_r6: assert property (@(posedge clk) disable iff (rst)
        play_state != 2'b01 && (play_filt_rst == (play_state == 2'b00)));

    p_legal_code_r8: assert property (@(posedge clk) disable iff (rst)
        cap_state != 2'b11 && play_state != 2'b11);
endmodule

bind cvt_pwr_seq cps_checker #(.DATA_W(DATA_W)) u_cps_checker (
    .clk           (clk),
    .rst           (rst),
    .cap_state     (cap_state),
    .play_state    (play_state),
    .cap_filt_rst  (cap_filt_rst),
    .play_filt_rst (play_filt_rst),
    .cap_din       (cap_din),
    .cap_dout      (cap_dout)
);

// File: tb/test_cvt_pwr_seq.sv
module test_cvt_pwr_seq;
    localparam int DW   = 20;
    localparam int INIT = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cap_pd_n = 1'b0;
    logic          play_pd_n = 1'b0;
    logic          lrck = 1'b0;
    logic [DW-1:0] cap_din = '0;
    logic [DW-1:0] cap_dout;
    logic          cap_filt_rst, play_filt_rst;
    logic [1:0]    cap_state, play_state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int         m_cnt  = 0;
    logic [1:0] m_cap  = 2'b00;
    logic [1:0] m_play = 2'b00;

    always #2 clk = ~clk;

    cvt_pwr_seq #(.DATA_W(DW), .INIT_LRCK(INIT), .SYNC_STAGES(2)) i_cvt_pwr_seq (
        .clk(clk), .rst(rst), .cap_pd_n(cap_pd_n), .play_pd_n(play_pd_n),
        .lrck(lrck), .cap_din(cap_din), .cap_dout(cap_dout),
        .cap_filt_rst(cap_filt_rst), .play_filt_rst(play_filt_rst),
        .cap_state(cap_state), .play_state(play_state)
    );

    function automatic logic [DW-1:0] exp_dout(logic [1:0] st, logic [DW-1:0] d);
        return (st == 2'b10) ? d : '0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        lrck = 1'b1; step(3);
        lrck = 1'b0; step(3);
        if (m_cap == 2'b01) begin
            m_cnt++;
            if (m_cnt == INIT) m_cap = 2'b10;
        end
    endtask

    task automatic set_cap(input logic v);
        cap_pd_n = v; step(3);
        m_cnt = 0;
        m_cap = v ? ((m_cap == 2'b10) ? 2'b10 : 2'b01) : 2'b00;
    endtask

    task automatic set_play(input logic v);
        play_pd_n = v; step(3);
        m_play = v ? 2'b10 : 2'b00;
    endtask

    task automatic check_all(input string tag);
        cap_din = DW'($urandom);
        #1;
        check({tag, " cap_state"}, 32'(cap_state), 32'(m_cap));
        check({tag, " play_state"}, 32'(play_state), 32'(m_play));
        check({tag, " cap_dout"}, 32'(cap_dout), 32'(exp_dout(m_cap, cap_din)));
        check({tag, " cap_filt_rst"}, 32'(cap_filt_rst), 32'(m_cap == 2'b00));
        check({tag, " play_filt_rst"}, 32'(play_filt_rst), 32'(m_play == 2'b00));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4551));
        step(4);
        cap_din = 20'hABCDE;
        #1;
        check("R1 reset cap_state", 32'(cap_state), 0);
        check("R1 reset dout", 32'(cap_dout), 0);
        check("R1 reset filt", 32'({cap_filt_rst, play_filt_rst}), 3);
        rst = 1'b0;
        step(1);
        check_all("R1 after reset");

        // R9: latency through the synchroniser
        cap_pd_n = 1'b1;
        step(2); #1;
        check("R9 not yet", 32'(cap_state), 0);
        step(1); #1;
        check("R9 seen, R3 init", 32'(cap_state), 1);
        m_cap = 2'b01; m_cnt = 0;
        check_all("R3 init entry");

        // R3: one short of the limit, then on it
        for (int i = 1; i < INIT; i++) begin
            pulse();
            check_all("R3 counting");
        end
        check("R3 one short", 32'(cap_state), 1);
        pulse();
        check("R3 at limit", 32'(cap_state), 2);
        for (int i = 0; i < 4; i++) check_all("R4 pass");

        // R2: power-down from normal
        set_cap(1'b0);
        check_all("R2 off");

        // R5: abort during init, then full count again
        set_cap(1'b1);
        pulse(); pulse(); pulse();
        check_all("R5 partial");
        set_cap(1'b0);
        check_all("R5 abort");
        set_cap(1'b1);
        for (int i = 1; i < INIT; i++) pulse();
        check("R5 cleared count", 32'(cap_state), 1);
        pulse();
        check("R5 full count", 32'(cap_state), 2);

        // R6 and R7: playback direct, no effect on capture count
        set_cap(1'b0);
        set_cap(1'b1);
        play_pd_n = 1'b1; step(2); #1;
        check("R6 play latency", 32'(play_state), 0);
        step(1); #1;
        check("R6 play direct", 32'(play_state), 2);
        m_play = 2'b10;
        pulse(); pulse();
        set_play(1'b0);
        check_all("R7 after play off");
        set_play(1'b1);
        pulse();
        check_all("R7 count kept");

        // random mix
        for (int i = 0; i < 120; i++) begin
            case ($urandom_range(5))
                0:       set_cap(~cap_pd_n);
                1:       set_play(~play_pd_n);
                default: pulse();
            endcase
            check_all("R2 R3 R4 R5 R7 random");
        end
        finish_run();
    end
endmodule